// File: doc/BRIEF.md
# Indirect Byte-Register Access Bridge

This block lets a host reach an 8-bit-address, 8-bit-data register file that runs on a separate, slower core clock. The host uses one 32-bit command word for every access. The word holds the target address, the byte to write and a direction flag. Writing the word starts the access. The bridge carries the command into the core domain and runs a request/acknowledge exchange with the register file. It then reports completion back in the host domain.

While an access is in flight, a busy flag in the same word stays set. When busy clears, a read access has placed the fetched byte in the top byte of the word. Software writes the word, polls until busy drops (giving up after roughly a millisecond), and then uses the result. Both directions of the crossing use toggle synchronizers. The command fields stay stable throughout an access, so they can be sampled safely in the other domain.

Top module: `byte_reg_bridge`

## Requirements
- R1: After reset the command word reads all zeros: busy (bit 23) is 0 and the read byte (bits [31:24]) is 0.
- R2: An accepted host write stores bits [7:0] as the address, bits [15:8] as the write byte and bit 16 as the direction (1 = write, 0 = read). These values read back at the same positions.
- R3: A write command (bit 16 = 1) produces exactly one register-file access with the write strobe high, carrying the stored address and byte.
- R4: A read command (bit 16 = 0) produces exactly one register-file access with the write strobe low. Once busy has cleared, bits [31:24] hold the byte the register file returned.
- R5: Busy (bit 23) is set from the cycle after an accepted host write and stays set until the access completes. The value written into bit 23 has no effect.
- R6: A host write while busy is set is ignored. The stored fields stay unchanged and no extra register-file access occurs.
- R7: A write command leaves the read byte (bits [31:24]) unchanged.
- R8: The register-file request stays high, with stable address, strobe and data, until it is acknowledged. It drops in the cycle after the acknowledge.
- R9: Bits [22:17] always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host-domain clock |
| host_rst | input | 1 | Synchronous active-high reset, host domain |
| host_wr_en | input | 1 | Host writes the command word this cycle |
| host_wr_word | input | 32 | Command word written by the host |
| host_rd_word | output | 32 | Current command/status word |
| core_clk | input | 1 | Core-domain clock |
| core_rst | input | 1 | Synchronous active-high reset, core domain |
| rf_req | output | 1 | Register-file access request |
| rf_we | output | 1 | 1 = write access, 0 = read access |
| rf_addr | output | 8 | Register-file address |
| rf_wdata | output | 8 | Byte to write |
| rf_ack | input | 1 | Register file completes the access |
| rf_rdata | input | 8 | Byte returned with the acknowledge |

## Verification
The main risk is a broken handshake across the clocks. A lost toggle leaves busy stuck high at the host port for as long as the polling window lasts. A duplicated toggle shows up as a second request on the register-file side within a few core cycles. The wrong byte latched on completion shows up in the top byte at the first poll after busy falls. Commands written while busy test whether the stored fields stay put, and the bench reads those fields back directly.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 8;
  localparam int WORD_W   = 32;
  localparam int ADDR_LSB = 0;
  localparam int WDAT_LSB = 8;
  localparam int DIR_BIT  = 16;
  localparam int BUSY_BIT = 23;
  localparam int RDAT_LSB = 24;
  localparam int PAD_W    = BUSY_BIT - DIR_BIT - 1;
endpackage

// File: rtl/bridge_toggle_sync.sv
module bridge_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tog_in,
  output logic pulse
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= tog_in;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign pulse = chain[STAGES-1] ^ last_q;
endmodule

// File: rtl/bridge_host.sv
module bridge_host
  import bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] rd_word,
  output logic              req_tog,
  input  logic              ack_tog,
  input  logic [DATA_W-1:0] core_rd,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_write
);
  logic              busy_q;
  logic [DATA_W-1:0] rd_q;
  logic              done;
  logic              accept;

  bridge_toggle_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst(rst), .tog_in(ack_tog), .pulse(done)
  );

  assign accept = wr_en && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      rd_q      <= '0;
      req_tog   <= 1'b0;
      cmd_addr  <= '0;
      cmd_wdata <= '0;
      cmd_write <= 1'b0;
    end else if (accept) begin
      busy_q    <= 1'b1;
      req_tog   <= ~req_tog;
      cmd_addr  <= wr_word[ADDR_LSB +: ADDR_W];
      cmd_wdata <= wr_word[WDAT_LSB +: DATA_W];
      cmd_write <= wr_word[DIR_BIT];
    end else if (busy_q && done) begin
      busy_q <= 1'b0;
      if (!cmd_write) rd_q <= core_rd;
    end
  end

  assign rd_word = {rd_q, busy_q, {PAD_W{1'b0}}, cmd_write, cmd_wdata, cmd_addr};

  AST_BUSY_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy_q) |=> busy_q); // R5
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy_q) |=> ($stable(cmd_addr) && $stable(cmd_wdata) && $stable(cmd_write))); // R6
  AST_WRITE_KEEPS_RD: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cmd_write) |=> $stable(rd_q)); // R7
endmodule

// File: rtl/bridge_core.sv
module bridge_core
  import bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_tog,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_write,
  output logic              ack_tog,
  output logic [DATA_W-1:0] rd_hold,
  output logic              rf_req,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  input  logic              rf_ack,
  input  logic [DATA_W-1:0] rf_rdata
);
  logic start;

  bridge_toggle_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst(rst), .tog_in(req_tog), .pulse(start)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_req   <= 1'b0;
      rf_we    <= 1'b0;
      rf_addr  <= '0;
      rf_wdata <= '0;
      ack_tog  <= 1'b0;
      rd_hold  <= '0;
    end else if (rf_req) begin
      if (rf_ack) begin
        rf_req  <= 1'b0;
        ack_tog <= ~ack_tog;
        if (!rf_we) rd_hold <= rf_rdata;
      end
    end else if (start) begin
      rf_req   <= 1'b1;
      rf_we    <= cmd_write;
      rf_addr  <= cmd_addr;
      rf_wdata <= cmd_wdata;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rf_req && !rf_ack) |=> rf_req); // R8
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (rf_req && !rf_ack) |=> ($stable(rf_addr) && $stable(rf_we) && $stable(rf_wdata))); // R8
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (rf_req && rf_ack) |=> !rf_req); // R8
endmodule

// File: rtl/byte_reg_bridge.sv
module byte_reg_bridge
  import bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              host_clk,
  input  logic              host_rst,
  input  logic              host_wr_en,
  input  logic [WORD_W-1:0] host_wr_word,
  output logic [WORD_W-1:0] host_rd_word,
  input  logic              core_clk,
  input  logic              core_rst,
  output logic              rf_req,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  input  logic              rf_ack,
  input  logic [DATA_W-1:0] rf_rdata
);
  logic              req_tog;
  logic              ack_tog;
  logic [DATA_W-1:0] rd_hold;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_wdata;
  logic              cmd_write;

  bridge_host #(.SYNC_STAGES(SYNC_STAGES)) u_host (
    .clk(host_clk), .rst(host_rst), .wr_en(host_wr_en), .wr_word(host_wr_word),
    .rd_word(host_rd_word), .req_tog(req_tog), .ack_tog(ack_tog), .core_rd(rd_hold),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_write(cmd_write)
  );

  bridge_core #(.SYNC_STAGES(SYNC_STAGES)) u_core (
    .clk(core_clk), .rst(core_rst), .req_tog(req_tog), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_write(cmd_write), .ack_tog(ack_tog), .rd_hold(rd_hold),
    .rf_req(rf_req), .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
    .rf_ack(rf_ack), .rf_rdata(rf_rdata)
  );

  AST_PAD_ZERO: assert property (@(posedge host_clk) disable iff (host_rst)
    host_rd_word[22:17] == 6'd0); // R9
endmodule

// File: tb/tb_byte_reg_bridge.sv
module tb_byte_reg_bridge;
  logic        host_clk = 0, host_rst = 1, host_wr_en = 0;
  logic [31:0] host_wr_word = '0, host_rd_word;
  logic        core_clk = 0, core_rst = 1;
  logic        rf_req, rf_we, rf_ack = 0;
  logic [7:0]  rf_addr, rf_wdata, rf_rdata = '0;

  int checks = 0, fails = 0, accesses = 0, wd = 0;
  logic [7:0] mem [256];
  int dly;

  byte_reg_bridge dut (.*);

  always #5 host_clk = ~host_clk;
  always #18.5 core_clk = ~core_clk;

  // register file model: acknowledges three core cycles after a request
  always @(posedge core_clk) begin
    if (rf_ack) begin
      rf_ack <= 1'b0;
      dly <= 0;
    end else if (rf_req) begin
      if (dly == 2) begin
        rf_ack <= 1'b1;
        accesses <= accesses + 1;
        if (rf_we) mem[rf_addr] <= rf_wdata;
        else rf_rdata <= mem[rf_addr];
      end else dly <= dly + 1;
    end else dly <= 0;
  end

  always @(posedge host_clk) begin
    wd <= wd + 1;
    if (wd == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [31:0] w);
    @(negedge host_clk);
    host_wr_en = 1; host_wr_word = w;
    @(negedge host_clk);
    host_wr_en = 0;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 2000; i++) begin
      if (!host_rd_word[23]) return;
      @(negedge host_clk);
    end
    chk("R5 busy timeout", host_rd_word[23], 0);
  endtask

  task automatic t_reset;
    chk("R1 reset word", host_rd_word, 32'h0);
  endtask

  task automatic t_write_access;
    int a0 = accesses;
    hwrite(32'h0001_5A3C);
    chk("R5 busy after write", host_rd_word[23], 1);
    chk("R2 fields", host_rd_word[16:0], 17'h15A3C);
    chk("R9 pad", host_rd_word[22:17], 0);
    wait_idle();
    chk("R3 one access", accesses - a0, 1);
    chk("R3 mem written", mem[8'h3C], 8'h5A);
    chk("R7 rdata kept", host_rd_word[31:24], 0);
  endtask

  task automatic t_read_access(logic [7:0] a, logic [7:0] v);
    int a0 = accesses;
    mem[a] = v;
    hwrite({8'h00, 1'b1, 7'h0, 8'hEE, a}); // bit23 written 1, dir=read
    chk("R2 dir read", host_rd_word[16], 0);
    chk("R5 busy set", host_rd_word[23], 1);
    wait_idle();
    chk("R4 rdata", host_rd_word[31:24], v);
    chk("R4 one access", accesses - a0, 1);
    chk("R9 pad", host_rd_word[22:17], 0);
  endtask

  task automatic t_ignore_busy;
    int a0 = accesses;
    mem[8'h10] = 8'h77;
    hwrite(32'h0000_0010);
    hwrite(32'h0001_99AB);
    chk("R6 fields kept", host_rd_word[16:0], 17'h00010);
    wait_idle();
    repeat (40) @(negedge host_clk);
    chk("R6 no extra access", accesses - a0, 1);
    chk("R6 mem untouched", mem[8'hAB] === 8'h99, 0);
    chk("R4 rdata", host_rd_word[31:24], 8'h77);
  endtask

  task automatic t_write_keeps;
    hwrite(32'h0001_0102);
    wait_idle();
    chk("R7 rdata unchanged", host_rd_word[31:24], 8'h77);
    chk("R3 mem", mem[8'h02], 8'h01);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (4) @(negedge core_clk);
    core_rst = 0;
    @(negedge host_clk);
    host_rst = 0;
    @(negedge host_clk);
    t_reset();
    t_write_access();
    t_read_access(8'h3C, 8'h5A);
    t_read_access(8'hFF, 8'hC3);
    t_read_access(8'h00, 8'h00);
    t_ignore_busy();
    t_write_keeps();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule